// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block turns a single asynchronous serial input into characters. A frame starts with a low start bit. The data bits follow least significant bit first. An optional parity bit comes next, then one or two high stop bits. An external baud generator supplies `sample_tick`, a one-cycle enable that pulses `OVERSAMPLE` times per bit period. The receiver counts these pulses to find the middle of each bit and samples the line once there.

Each finished character may be written into a receive buffer, and a ready flag tells software that a character is waiting. The block checks every frame for framing and parity errors. It also reports overrun, and it reports a line held low for too long as a break. Each of these conditions sets a sticky flag, and a summary flag is set whenever any of them occurs. A mode input chooses between storing every character and storing only clean ones. While the framing, parity, break or summary flag is set, the ready flag cannot rise again. A software-reset input holds all status at zero.

Top module: `serial_rx_core`

## Requirements
- R1: Data bits arrive least significant bit first, right after the start bit. When `cfg_len8`=1 all 8 bits go to `rx_data`. When `cfg_len8`=0, 7 bits are received and `rx_data[7]` reads 0.
- R2: When `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_par_even`=1 the data bits plus the parity bit hold an even number of ones; with `cfg_par_even`=0 they hold an odd number. A mismatch sets `err_parity`.
- R3: `cfg_two_stop` selects one stop bit (0) or two (1). A stop bit sampled low sets `err_frame`.
- R4: If a character completes while `rx_ready` is 1 and no read occurs in that cycle, `err_overrun` is set.
- R5: If the line stays low for more than 10 bit times, `err_break` is set. The line is counted as low for more than 10*OVERSAMPLE ticks.
- R6: `err_any` is set in the same cycle that any of the frame, parity, overrun or break conditions is recorded.
- R7: With `cfg_keep_all`=0, a character with a framing or parity error leaves `rx_data` unchanged. With `cfg_keep_all`=1, every character is written.
- R8: A written character sets `rx_ready` only if `err_frame`, `err_parity`, `err_break` and `err_any` were all clear before it completed. `err_overrun` alone does not block it.
- R9: While `soft_rst` is 1, every error flag and `rx_ready` read 0 one cycle later, and incoming frames are not received.
- R10: A low pulse on the line that is high again by the middle of the start bit does not start a frame.
- R11: `rd_strobe` clears `rx_ready`. Each bit of `err_clr` clears one flag: bit 0 frame, bit 1 parity, bit 2 overrun, bit 3 break, bit 4 summary. When a character completes in the same cycle as a read, `rx_ready` ends at 1 and no overrun is recorded.
- R12: After `rst`, `rx_data` is 0 and `rx_ready` and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Software reset; holds status at zero |
| sample_tick | input | 1 | Bit-timing enable, OVERSAMPLE pulses per bit |
| rxd | input | 1 | Serial input line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1: even parity, 0: odd parity |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_keep_all | input | 1 | 1: store every character, 0: clean ones only |
| rd_strobe | input | 1 | Buffer read; clears the ready flag |
| err_clr | input | 5 | Per-flag clear mask |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Character waiting |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_break | output | 1 | Sticky break |
| err_any | output | 1 | Sticky summary error |

## Verification
A buffer read and the completion of a new character can fall in the same clock cycle. When they do, the result must be a set ready flag and no overrun. The bench forces this case by sweeping the cycle of a one-cycle read pulse, one clock at a time, across the stop bit of a second unread character. For every offset, the pair (ready, overrun) must be either (1,0), where the read came first or in the same cycle, or (0,1), where the read came after. Both outcomes must appear somewhere in the sweep, and the pair (0,0) counts as a failure.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_ARM, ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_t;

  typedef struct packed {
    logic [CHAR_W-1:0] data;
    logic              fe;
    logic              pe;
  } rx_char_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     hold,
  input  logic     tick,
  input  logic     line,
  input  logic     len8,
  input  logic     par_en,
  input  logic     par_even,
  input  logic     two_stop,
  output logic     done,
  output rx_char_t chr
);
  localparam int CW = (OVERSAMPLE > 2) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(OVERSAMPLE - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(OVERSAMPLE / 2 - 1);

  rx_state_t         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        idx;
  logic [CHAR_W-1:0] sr;
  logic              fe_acc, pe_acc;
  logic              at_mid;
  logic [2:0]        last_idx;
  logic              exp_par;

  assign at_mid   = tick && (cnt == LAST_CNT);
  assign last_idx = len8 ? 3'd7 : 3'd6;
  assign exp_par  = par_even ? (^sr) : ~(^sr);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state  <= ST_ARM;
      cnt    <= '0;
      idx    <= '0;
      sr     <= '0;
      fe_acc <= 1'b0;
      pe_acc <= 1'b0;
      done   <= 1'b0;
      chr    <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_ARM:  if (line) state <= ST_IDLE;
        ST_IDLE: if (tick && !line) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (tick) begin
          if (cnt == HALF_CNT) begin
            cnt <= '0;
            if (line) begin
              state <= ST_IDLE;
            end else begin
              state  <= ST_DATA;
              idx    <= '0;
              sr     <= '0;
              fe_acc <= 1'b0;
              pe_acc <= 1'b0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          if (at_mid) begin
            cnt     <= '0;
            sr[idx] <= line;
            if (idx == last_idx) state <= par_en ? ST_PAR : ST_STOP1;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: if (tick) begin
          if (at_mid) begin
            cnt    <= '0;
            pe_acc <= (line != exp_par);
            state  <= ST_STOP1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP1: if (tick) begin
          if (at_mid) begin
            cnt <= '0;
            if (two_stop) begin
              fe_acc <= !line;
              state  <= ST_STOP2;
            end else begin
              done     <= 1'b1;
              chr.data <= sr;
              chr.fe   <= !line;
              chr.pe   <= pe_acc;
              state    <= ST_ARM;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP2: if (tick) begin
          if (at_mid) begin
            cnt      <= '0;
            done     <= 1'b1;
            chr.data <= sr;
            chr.fe   <= fe_acc | !line;
            chr.pe   <= pe_acc;
            state    <= ST_ARM;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_ARM;
      endcase
    end
  end
endmodule

// File: rtl/rx_break_watch.sv
module rx_break_watch #(
  parameter int OVERSAMPLE = 8,
  parameter int BREAK_BITS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic tick,
  input  logic line,
  output logic brk_evt
);
  localparam int LIMIT = BREAK_BITS * OVERSAMPLE;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] LIM  = CW'(LIMIT);
  localparam logic [CW-1:0] SATV = CW'(LIMIT + 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      low_cnt <= '0;
      brk_evt <= 1'b0;
    end else begin
      brk_evt <= 1'b0;
      if (line) begin
        low_cnt <= '0;
      end else if (tick && low_cnt != SATV) begin
        low_cnt <= low_cnt + 1'b1;
        if (low_cnt == LIM) brk_evt <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              done,
  input  rx_char_t          chr,
  input  logic              brk_evt,
  input  logic              keep_all,
  input  logic              rd_strobe,
  input  logic [4:0]        err_clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              fe,
  output logic              pe,
  output logic              ovr,
  output logic              brk,
  output logic              any
);
  logic bad_char, blocked, store;

  assign bad_char = chr.fe | chr.pe;
  assign blocked  = fe | pe | brk | any;
  assign store    = keep_all | !bad_char;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      fe <= 1'b0; pe <= 1'b0; ovr <= 1'b0; brk <= 1'b0; any <= 1'b0;
    end else if (hold) begin
      rx_ready <= 1'b0;
      fe <= 1'b0; pe <= 1'b0; ovr <= 1'b0; brk <= 1'b0; any <= 1'b0;
    end else begin
      if (err_clr[0]) fe  <= 1'b0;
      if (err_clr[1]) pe  <= 1'b0;
      if (err_clr[2]) ovr <= 1'b0;
      if (err_clr[3]) brk <= 1'b0;
      if (err_clr[4]) any <= 1'b0;
      if (rd_strobe)  rx_ready <= 1'b0;
      if (brk_evt) begin
        brk <= 1'b1;
        any <= 1'b1;
      end
      if (done) begin
        if (chr.fe)   fe  <= 1'b1;
        if (chr.pe)   pe  <= 1'b1;
        if (bad_char) any <= 1'b1;
        if (rx_ready && !rd_strobe) begin
          ovr <= 1'b1;
          any <= 1'b1;
        end
        if (store) begin
          rx_data <= chr.data;
          if (!blocked) rx_ready <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BREAK_BITS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              sample_tick,
  input  logic              rxd,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_even,
  input  logic              cfg_two_stop,
  input  logic              cfg_keep_all,
  input  logic              rd_strobe,
  input  logic [4:0]        err_clr,
  output logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              err_frame,
  output logic              err_parity,
  output logic              err_overrun,
  output logic              err_break,
  output logic              err_any
);
  logic     line_s;
  logic     frm_done;
  rx_char_t frm_chr;
  logic     frm_fe, frm_pe;
  logic     brk_evt;

  assign frm_fe = frm_chr.fe;
  assign frm_pe = frm_chr.pe;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line_s)
  );

  rx_frame_fsm #(.OVERSAMPLE(OVERSAMPLE)) u_frame (
    .clk(clk), .rst(rst), .hold(soft_rst), .tick(sample_tick), .line(line_s),
    .len8(cfg_len8), .par_en(cfg_par_en), .par_even(cfg_par_even),
    .two_stop(cfg_two_stop), .done(frm_done), .chr(frm_chr)
  );

  rx_break_watch #(.OVERSAMPLE(OVERSAMPLE), .BREAK_BITS(BREAK_BITS)) u_break (
    .clk(clk), .rst(rst), .hold(soft_rst), .tick(sample_tick), .line(line_s),
    .brk_evt(brk_evt)
  );

  rx_status_regs u_status (
    .clk(clk), .rst(rst), .hold(soft_rst), .done(frm_done), .chr(frm_chr),
    .brk_evt(brk_evt), .keep_all(cfg_keep_all), .rd_strobe(rd_strobe),
    .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .fe(err_frame), .pe(err_parity), .ovr(err_overrun), .brk(err_break),
    .any(err_any)
  );
endmodule

// File: rtl/serial_rx_core_chk.sv
module serial_rx_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       soft_rst,
  input logic       rd_strobe,
  input logic       cfg_keep_all,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun,
  input logic       err_break,
  input logic       err_any,
  input logic       frm_done,
  input logic       frm_fe,
  input logic       frm_pe,
  input logic       line_s
);
  assert_softrst_hold_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !(rx_ready || err_frame || err_parity || err_overrun || err_break || err_any));

  assert_summary_follows_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(err_frame) || $rose(err_parity) || $rose(err_overrun) || $rose(err_break)) |-> err_any);

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frm_done) |=> !rx_ready);

  assert_ready_gated_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_ready) |-> !$past(err_frame || err_parity || err_break || err_any));

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(err_overrun) |-> $past(rx_ready));

  assert_bad_not_stored_R7: assert property (@(posedge clk) disable iff (rst)
    (frm_done && !cfg_keep_all && (frm_fe || frm_pe) && !soft_rst) |=> $stable(rx_data));

  assert_break_low_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(err_break) |-> !$past(line_s, 2));
endmodule

bind serial_rx_core serial_rx_core_chk u_chk (.*);

// File: tb/serial_rx_core_tb_top.sv
module serial_rx_core_tb_top;
  localparam int OVS    = 8;
  localparam int BITCLK = OVS * 2;

  logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic len8 = 1'b1, par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0, keep_all = 1'b0;
  logic rd_strobe = 1'b0;
  logic [4:0] err_clr = '0;
  logic [7:0] rx_data;
  logic rx_ready, err_frame, err_parity, err_overrun, err_break, err_any;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  serial_rx_core #(.OVERSAMPLE(OVS)) dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .sample_tick(tick), .rxd(rxd),
    .cfg_len8(len8), .cfg_par_en(par_en), .cfg_par_even(par_even),
    .cfg_two_stop(two_stop), .cfg_keep_all(keep_all), .rd_strobe(rd_strobe),
    .err_clr(err_clr), .rx_data(rx_data), .rx_ready(rx_ready),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .err_break(err_break), .err_any(err_any)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic p;
    int n;
    n = len8 ? 8 : 7;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (par_en) begin
      p = len8 ? ^d : ^d[6:0];
      if (!par_even) p = ~p;
      send_bit(p ^ bad_par);
    end
    send_bit(~bad_stop);
    if (two_stop) send_bit(1'b1);
    rxd = 1'b1;
  endtask

  task automatic idle(input int bits);
    repeat (bits * BITCLK) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
  endtask

  task automatic clear_all();
    err_clr = '1; @(negedge clk); err_clr = '0;
  endtask

  task automatic set_cfg(input logic l8, input logic pe, input logic ev,
                         input logic ts, input logic ka);
    len8 = l8; par_en = pe; par_even = ev; two_stop = ts; keep_all = ka;
  endtask

  function automatic int flags();
    return {err_any, err_break, err_overrun, err_parity, err_frame};
  endfunction

  task automatic run_all();
    logic [7:0] exp_buf, d, m;
    logic bp, bs, errc, ld;
    int seen_first, seen_late;
    // R12 reset state
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12 rx_data", rx_data, 0);
    check("R12 rx_ready", rx_ready, 0);
    check("R12 flags", flags(), 0);
    idle(1);

    // Sweep every configuration with clean, bad-parity and bad-stop frames
    exp_buf = 8'h00;
    for (int cfg = 0; cfg < 32; cfg++) begin
      set_cfg(cfg[0], cfg[1], cfg[2], cfg[3], cfg[4]);
      for (int v = 0; v < 4; v++) begin
        d    = 8'((cfg * 53 + v * 29 + 7) & 255);
        bp   = (v == 1) && par_en;
        bs   = (v == 2);
        errc = bp | bs;
        m    = len8 ? d : {1'b0, d[6:0]};
        ld   = keep_all | !errc;
        if (ld) exp_buf = m;
        send_frame(d, bp, bs);
        idle(2);
        check("R1 R7 rx_data", rx_data, exp_buf);
        check("R7 rx_ready", rx_ready, ld);
        check("R3 err_frame", err_frame, bs);
        check("R2 err_parity", err_parity, bp);
        check("R6 err_any", err_any, errc);
        pulse_rd();
        clear_all();
      end
    end

    // R4 overrun, R8 overrun alone does not block
    set_cfg(1, 0, 0, 0, 0);
    send_frame(8'h11, 0, 0); idle(1);
    send_frame(8'h22, 0, 0); idle(2);
    check("R4 rx_data", rx_data, 8'h22);
    check("R4 rx_ready", rx_ready, 1);
    check("R4 err_overrun", err_overrun, 1);
    check("R6 err_any on overrun", err_any, 1);
    err_clr = 5'b10000; @(negedge clk); err_clr = '0;
    check("R11 per-flag clear keeps overrun", flags(), 5'b00100);
    pulse_rd();
    send_frame(8'h33, 0, 0); idle(2);
    check("R8 overrun does not block", rx_ready, 1);
    check("R8 rx_data", rx_data, 8'h33);
    pulse_rd(); clear_all();
    check("R11 rd and clear", {rx_ready, flags()}, 0);

    // R7 keep-all stores bad characters, R8 sticky error blocks ready
    set_cfg(1, 1, 1, 0, 1);
    send_frame(8'h4D, 1, 0); idle(2);
    check("R7 keep-all stores bad", rx_data, 8'h4D);
    check("R8 ready on first error", rx_ready, 1);
    check("R2 parity flag", err_parity, 1);
    pulse_rd();
    send_frame(8'h5E, 0, 0); idle(2);
    check("R7 keep-all stores next", rx_data, 8'h5E);
    check("R8 blocked by sticky error", rx_ready, 0);
    clear_all();
    send_frame(8'h6F, 0, 0); idle(2);
    check("R8 unblocked after clear", rx_ready, 1);
    pulse_rd();

    // R11 read and completion in the same cycle: sweep read offset
    set_cfg(1, 0, 0, 0, 0);
    seen_first = 0; seen_late = 0;
    for (int k = 0; k < 24; k++) begin
      send_frame(8'hA5, 0, 0); idle(1);
      fork
        send_frame(8'h5A, 0, 0);
        begin
          repeat (9 * BITCLK + k) @(negedge clk);
          rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0;
        end
      join
      idle(2);
      if (rx_ready && !err_overrun) seen_first++;
      if (!rx_ready && err_overrun) seen_late++;
      check("R11 coincident read outcome", (rx_ready != err_overrun), 1);
      check("R11 rx_data", rx_data, 8'h5A);
      pulse_rd(); clear_all();
    end
    check("R11 read-first outcome seen", seen_first > 0, 1);
    check("R11 read-late outcome seen", seen_late > 0, 1);

    // R10 glitch rejection
    rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    idle(3);
    check("R10 glitch no ready", rx_ready, 0);
    check("R10 glitch no flags", flags(), 0);
    send_frame(8'h3C, 0, 0); idle(2);
    check("R10 frame after glitch", rx_data, 8'h3C);
    check("R10 ready after glitch", rx_ready, 1);
    pulse_rd();

    // R5 break
    rxd = 1'b0;
    repeat (9 * BITCLK) @(negedge clk);
    check("R5 no break at 9 bits", err_break, 0);
    repeat (2 * BITCLK) @(negedge clk);
    check("R5 break at 11 bits", err_break, 1);
    check("R6 any on break", err_any, 1);
    check("R3 frame error on break", err_frame, 1);
    rxd = 1'b1; idle(2);
    check("R7 break char not stored", rx_ready, 0);
    clear_all();

    // R9 software reset
    send_frame(8'h77, 0, 0); idle(1);
    send_frame(8'h88, 0, 0); idle(2);
    check("R9 setup overrun", err_overrun, 1);
    soft_rst = 1'b1; repeat (2) @(negedge clk);
    check("R9 ready held", rx_ready, 0);
    check("R9 flags held", flags(), 0);
    send_frame(8'h99, 0, 1); idle(2);
    check("R9 frame ignored in reset", {rx_ready, flags()}, 0);
    soft_rst = 1'b0; idle(1);
    send_frame(8'hC3, 0, 0); idle(2);
    check("R9 receive after release", rx_data, 8'hC3);
    check("R9 ready after release", rx_ready, 1);
  endtask

  initial begin
    run_all();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R12 actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule